// File: doc/BRIEF.md
# Double-Buffered Serial Code Input Stage

This block models the digital front end of a serially loaded multiplying converter. A host presents one data bit and a serial clock; every rising serial-clock edge pushes the bit into a 12-bit shift register, most significant bit first. A separate active-low load strobe copies the shift register into a 12-bit holding register. The holding register's contents appear on a parallel code output, which stands in for the converter. The load is level sensitive: for as long as the strobe stays low, the holding register tracks the shift register, including bits that arrive while it is low.

All three host inputs are sampled by a fast reference clock, which runs the whole model. A timing monitor measures, in reference-clock cycles, the data setup and hold around each serial-clock rise, the high and low widths of the serial clock, and the width of the load pulse. Any interval that falls short sets a sticky violation flag. A short-word flag reports whether each load began with fewer than twelve bits collected since the previous load ended. Bits older than the last twelve are dropped without any indication.

Top module: `sdac_input_reg`

## Requirements
- R1: An active-high synchronous reset clears the code output to 0, clears the short-word flag and the timing-violation flag, and empties the bit count. No load occurs until the strobe is next seen low.
- R2: Each rising edge of the serial clock, as seen in the reference-clock samples, shifts exactly one data bit into the shift register. The bit shifted is the data value sampled together with that rise.
- R3: Bits enter most significant first: for a 12-bit frame, the first bit sent ends up in code bit 11 and the last bit sent ends up in code bit 0.
- R4: When more than 12 bits are shifted, only the 12 most recent remain: the code then equals the last 12 bits sent, in order.
- R5: While the load strobe is low, the code output follows the shift register, and bits shifted during that time appear on the code. While the strobe is high, shifting leaves the code unchanged.
- R6: At each high-to-low transition of the load strobe, the short-word flag is set if fewer than 12 bits were shifted since the previous load ended, and cleared if 12 or more were shifted. It keeps that value until the next load.
- R7: A serial-clock rise seen in the same sample as the load strobe going low is counted toward the word and appears on the code. With 11 bits already shifted, such a final edge yields a full word and a cleared short-word flag.
- R8: The timing-violation flag is set, and stays set until reset, when any of these limits is broken: data stable less than 5 samples before a serial-clock rise, data changing less than 10 samples after a rise, serial clock high less than 12 samples, serial clock low less than 15 samples, or a load pulse shorter than 15 samples. These defaults are 40, 80, 90, 120 and 120 ns at an 8 ns reference period, rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; samples all host inputs |
| rst | input | 1 | Synchronous reset, active high |
| ser_din | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial clock; rising edge shifts a bit |
| load_n | input | 1 | Load strobe, active low, level sensitive |
| code_out | output | 12 | Holding register contents (converter code) |
| short_word | output | 1 | Last load began with fewer than 12 new bits |
| timing_viol | output | 1 | Sticky flag for a broken timing limit |

## Verification
The final serial-clock rise and the falling edge of the load strobe can arrive in the same reference sample, because the load may follow the last clock edge with no delay. The bench shifts eleven bits, then raises the serial clock and lowers the load strobe in the same drive step. It then checks three things: the code carries all twelve bits, the short-word flag is clear, and no timing violation is reported. A second case clocks bits in while the strobe is already low, and checks that each bit reaches the code without another load.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Elapsed-sample counters used by the timing monitor.
  typedef logic [7:0] sdac_age_t;

  // Events derived from two consecutive reference samples.
  typedef struct packed {
    logic din;       // data bit in the newest sample
    logic din_chg;   // data differs from the previous sample
    logic sck_rise;  // serial clock went 0 -> 1
    logic sck_fall;  // serial clock went 1 -> 0
    logic ld_low;    // strobe low in the newest sample
    logic ld_fall;   // strobe went 1 -> 0
    logic ld_rise;   // strobe went 0 -> 1
  } sdac_evt_t;

  // Nanosecond minimum converted to whole reference samples, rounded up.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  // Saturating increment of an elapsed-sample counter.
  function automatic sdac_age_t age_step(input sdac_age_t a);
    return (a == 8'hFF) ? a : a + 8'd1;
  endfunction

endpackage

// File: rtl/sdac_sampler.sv
module sdac_sampler
  import sdac_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ser_din,
  input  logic      ser_clk,
  input  logic      load_n,
  output sdac_evt_t evt
);

  logic din_q, sck_q, ld_q;
  logic din_p, sck_p, ld_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= 1'b0;
      sck_q <= 1'b0;
      ld_q  <= 1'b1;
      din_p <= 1'b0;
      sck_p <= 1'b0;
      ld_p  <= 1'b1;
    end else begin
      din_q <= ser_din;
      sck_q <= ser_clk;
      ld_q  <= load_n;
      din_p <= din_q;
      sck_p <= sck_q;
      ld_p  <= ld_q;
    end
  end

  always_comb begin
    evt.din      = din_q;
    evt.din_chg  = din_q ^ din_p;
    evt.sck_rise = sck_q & ~sck_p;
    evt.sck_fall = ~sck_q & sck_p;
    evt.ld_low   = ~ld_q;
    evt.ld_fall  = ~ld_q & ld_p;
    evt.ld_rise  = ld_q & ~ld_p;
  end

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_ev,
  input  logic         bit_in,
  input  logic         ld_low,
  output logic [W-1:0] shreg,
  output logic         word_full
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_plus;

  // Count as it stands including a bit arriving in this very sample.
  always_comb begin
    cnt_plus = cnt;
    if (shift_ev && cnt < FULL) cnt_plus = cnt + 1'b1;
  end
  assign word_full = (cnt_plus == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      if (shift_ev) shreg <= {shreg[W-2:0], bit_in};
      if (ld_low) cnt <= '0;
      else        cnt <= cnt_plus;
    end
  end

  p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
    shift_ev |=> (shreg == {$past(shreg[W-2:0]), $past(bit_in)}));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

endmodule

// File: rtl/sdac_holder.sv
module sdac_holder #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_low,
  input  logic         ld_fall,
  input  logic         word_full,
  input  logic [W-1:0] shreg,
  output logic [W-1:0] code,
  output logic         short_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code       <= '0;
      short_word <= 1'b0;
    end else begin
      if (ld_low)  code       <= shreg;
      if (ld_fall) short_word <= ~word_full;
    end
  end

  p_follow_r5: assert property (@(posedge clk) disable iff (rst)
    ld_low |=> (code == $past(shreg)));

  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !ld_low |=> $stable(code));

  p_full_clears_short_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_fall && word_full) |=> !short_word);

endmodule

// File: rtl/sdac_timing_mon.sv
module sdac_timing_mon
  import sdac_pkg::*;
#(
  parameter int unsigned REF_NS   = 8,
  parameter int unsigned SETUP_NS = 40,
  parameter int unsigned HOLD_NS  = 80,
  parameter int unsigned HIGH_NS  = 90,
  parameter int unsigned LOW_NS   = 120,
  parameter int unsigned LOAD_NS  = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic din_chg,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic ld_fall,
  input  logic ld_rise,
  output logic viol
);

  localparam sdac_age_t SETUP_C = 8'(ns_to_cyc(SETUP_NS, REF_NS));
  localparam sdac_age_t HOLD_C  = 8'(ns_to_cyc(HOLD_NS,  REF_NS));
  localparam sdac_age_t HIGH_C  = 8'(ns_to_cyc(HIGH_NS,  REF_NS));
  localparam sdac_age_t LOW_C   = 8'(ns_to_cyc(LOW_NS,   REF_NS));
  localparam sdac_age_t LOAD_C  = 8'(ns_to_cyc(LOAD_NS,  REF_NS));
  localparam int NAGE = 4;

  // Index: 0 data change, 1 clock rise, 2 clock fall, 3 strobe fall.
  logic      [NAGE-1:0] restart;
  logic      [NAGE-1:0] seen;
  sdac_age_t            age [NAGE];

  assign restart = {ld_fall, sck_fall, sck_rise, din_chg};

  for (genvar i = 0; i < NAGE; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age[i]  <= '0;
        seen[i] <= 1'b0;
      end else if (restart[i]) begin
        age[i]  <= 8'd1;
        seen[i] <= 1'b1;
      end else begin
        age[i]  <= age_step(age[i]);
      end
    end
  end

  logic setup_bad, hold_bad, high_bad, low_bad, load_bad;

  assign setup_bad = sck_rise && (din_chg || age[0] < SETUP_C);
  assign hold_bad  = din_chg && !sck_rise && seen[1] && age[1] < HOLD_C;
  assign high_bad  = sck_fall && seen[1] && age[1] < HIGH_C;
  assign low_bad   = sck_rise && seen[2] && age[2] < LOW_C;
  assign load_bad  = ld_rise && seen[3] && age[3] < LOAD_C;

  always_ff @(posedge clk) begin
    if (rst) viol <= 1'b0;
    else if (setup_bad | hold_bad | high_bad | low_bad | load_bad) viol <= 1'b1;
  end

  p_viol_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    viol |=> viol);

  p_viol_needs_event_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(viol) |-> $past(din_chg | sck_rise | sck_fall | ld_rise));

endmodule

// File: rtl/sdac_input_reg.sv
module sdac_input_reg
  import sdac_pkg::*;
#(
  parameter int          W        = 12,
  parameter int unsigned REF_NS   = 8,
  parameter int unsigned SETUP_NS = 40,
  parameter int unsigned HOLD_NS  = 80,
  parameter int unsigned HIGH_NS  = 90,
  parameter int unsigned LOW_NS   = 120,
  parameter int unsigned LOAD_NS  = 120
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_din,
  input  logic         ser_clk,
  input  logic         load_n,
  output logic [W-1:0] code_out,
  output logic         short_word,
  output logic         timing_viol
);

  sdac_evt_t    evt;
  logic [W-1:0] shreg;
  logic         word_full;

  sdac_sampler u_samp (
    .clk     (clk),
    .rst     (rst),
    .ser_din (ser_din),
    .ser_clk (ser_clk),
    .load_n  (load_n),
    .evt     (evt)
  );

  sdac_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_ev  (evt.sck_rise),
    .bit_in    (evt.din),
    .ld_low    (evt.ld_low),
    .shreg     (shreg),
    .word_full (word_full)
  );

  sdac_holder #(.W(W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .ld_low     (evt.ld_low),
    .ld_fall    (evt.ld_fall),
    .word_full  (word_full),
    .shreg      (shreg),
    .code       (code_out),
    .short_word (short_word)
  );

  sdac_timing_mon #(
    .REF_NS   (REF_NS),
    .SETUP_NS (SETUP_NS),
    .HOLD_NS  (HOLD_NS),
    .HIGH_NS  (HIGH_NS),
    .LOW_NS   (LOW_NS),
    .LOAD_NS  (LOAD_NS)
  ) u_tmon (
    .clk      (clk),
    .rst      (rst),
    .din_chg  (evt.din_chg),
    .sck_rise (evt.sck_rise),
    .sck_fall (evt.sck_fall),
    .ld_fall  (evt.ld_fall),
    .ld_rise  (evt.ld_rise),
    .viol     (timing_viol)
  );

  // A bit shifted while the strobe is low reaches the code two samples later.
  p_transparent_path_r7: assert property (@(posedge clk) disable iff (rst)
    (evt.sck_rise && evt.ld_low) |=> ##1 (!evt.ld_low || code_out[0] == $past(evt.din, 2)));

endmodule

// File: tb/sdac_input_reg_tb_top.sv
module sdac_input_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_din = 1'b0;
  logic        ser_clk = 1'b0;
  logic        load_n = 1'b1;
  logic [11:0] code_out;
  logic        short_word;
  logic        timing_viol;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [11:0] m_sh = '0;
  logic [11:0] m_code = '0;
  int          m_cnt = 0;

  always #4 clk = ~clk;

  sdac_input_reg dut_i (
    .clk         (clk),
    .rst         (rst),
    .ser_din     (ser_din),
    .ser_clk     (ser_clk),
    .load_n      (load_n),
    .code_out    (code_out),
    .short_word  (short_word),
    .timing_viol (timing_viol)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ser_clk = 1'b0; ser_din = 1'b0; load_n = 1'b1;
    wait_n(3);
    rst = 1'b0;
    m_sh = '0; m_code = '0; m_cnt = 0;
    wait_n(20);
  endtask

  // One well-timed bit: setup 8, high 16, low 16 samples.
  task automatic send_bit(input logic b);
    ser_din = b;
    wait_n(8);
    ser_clk = 1'b1;
    m_sh = {m_sh[10:0], b};
    if (load_n) begin
      if (m_cnt < 12) m_cnt++;
    end else begin
      m_code = m_sh;
    end
    wait_n(16);
    ser_clk = 1'b0;
    wait_n(16);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_n(20);
    load_n = 1'b1;
    m_code = m_sh;
    wait_n(4);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 code", code_out, 12'h000);
    chk("R1 short", {11'd0, short_word}, 12'd0);
    chk("R1 viol", {11'd0, timing_viol}, 12'd0);
  endtask

  task automatic t_full_word();
    send_bits(16'h0A5C, 12);
    pulse_load();
    chk("R3 msb-first word", code_out, 12'hA5C);
    chk("R6 full word short", {11'd0, short_word}, 12'd0);
    chk("R8 clean timing", {11'd0, timing_viol}, 12'd0);
  endtask

  task automatic t_hold_without_load();
    send_bits(16'h0123, 12);
    chk("R5 code held while strobe high", code_out, 12'hA5C);
    pulse_load();
    chk("R2 one bit per rise", code_out, 12'h123);
  endtask

  task automatic t_overlong();
    send_bits(16'hF0A5, 16);
    pulse_load();
    chk("R4 last twelve kept", code_out, 12'h0A5);
    chk("R4 short after overlong", {11'd0, short_word}, 12'd0);
  endtask

  task automatic t_short();
    send_bits(16'h0016, 5);
    pulse_load();
    chk("R6 short value", code_out, m_code);
    chk("R6 short flag", {11'd0, short_word}, 12'd1);
    send_bits(16'h0FFF, 12);
    pulse_load();
    chk("R6 flag cleared by full word", {11'd0, short_word}, 12'd0);
    chk("R6 full ones", code_out, 12'hFFF);
  endtask

  task automatic t_transparent();
    load_n = 1'b0;
    wait_n(4);
    for (int i = 0; i < 4; i++) begin
      send_bit(i[0]);
      chk("R5 follows while low", code_out, m_code);
    end
    load_n = 1'b1;
    wait_n(4);
    send_bits(16'h0003, 2);
    chk("R5 frozen after strobe rise", code_out, m_code);
    chk("R8 transparent timing", {11'd0, timing_viol}, 12'd0);
  endtask

  task automatic t_coincide();
    pulse_load();
    send_bits(16'h0264, 11);
    ser_din = 1'b1;
    wait_n(8);
    ser_clk = 1'b1;
    load_n  = 1'b0;
    wait_n(16);
    ser_clk = 1'b0;
    wait_n(4);
    load_n = 1'b1;
    wait_n(4);
    chk("R7 last edge with load", code_out, 12'h4C9);
    chk("R7 counted as full", {11'd0, short_word}, 12'd0);
    chk("R7 no violation", {11'd0, timing_viol}, 12'd0);
  endtask

  task automatic t_setup_viol();
    do_reset();
    ser_din = 1'b1;
    wait_n(1);
    ser_clk = 1'b1;
    wait_n(16);
    ser_clk = 1'b0;
    wait_n(16);
    chk("R8 setup", {11'd0, timing_viol}, 12'd1);
    wait_n(40);
    chk("R8 sticky", {11'd0, timing_viol}, 12'd1);
    do_reset();
    chk("R1 reset clears viol", {11'd0, timing_viol}, 12'd0);
  endtask

  task automatic t_hold_viol();
    ser_din = 1'b1;
    wait_n(8);
    ser_clk = 1'b1;
    wait_n(2);
    ser_din = 1'b0;
    wait_n(14);
    ser_clk = 1'b0;
    wait_n(16);
    chk("R8 hold", {11'd0, timing_viol}, 12'd1);
    do_reset();
  endtask

  task automatic t_width_viol();
    ser_din = 1'b1;
    wait_n(8);
    ser_clk = 1'b1;
    wait_n(3);
    ser_clk = 1'b0;
    wait_n(20);
    chk("R8 clock high width", {11'd0, timing_viol}, 12'd1);
    do_reset();
    send_bit(1'b1);
    ser_clk = 1'b1;
    wait_n(16);
    ser_clk = 1'b0;
    wait_n(3);
    ser_clk = 1'b1;
    wait_n(16);
    ser_clk = 1'b0;
    wait_n(16);
    chk("R8 clock low width", {11'd0, timing_viol}, 12'd1);
    do_reset();
    load_n = 1'b0;
    wait_n(3);
    load_n = 1'b1;
    wait_n(4);
    chk("R8 load width", {11'd0, timing_viol}, 12'd1);
    do_reset();
  endtask

  initial begin
    t_reset_state();
    t_full_word();
    t_hold_without_load();
    t_overlong();
    t_short();
    t_transparent();
    t_coincide();
    t_setup_viol();
    t_hold_viol();
    t_width_viol();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule